// File: doc/BRIEF.md
# Multi-Mode Timer with Compare, PWM, One-Shot and Capture

A 10-bit up-counter with two comparators. The counter advances on a one-cycle `tick` enable, which comes from an external prescaler. It runs while a run flag is set and a pause input is low. Comparator A checks the full count against CCRA. Comparator P checks only the three top count bits against CCRP, so the P period is CCRP × 128 counts, and CCRP = 0 gives the full 1024-count range. A two-bit mode input picks what the block does with these matches:

- compare-match output,
- input capture,
- PWM,
- a single pulse.

The block drives one waveform pin and its complement. It raises separate one-cycle A and P event flags. It exposes the count, CCRA and CCRP as readable outputs, with write strobes for CCRA and CCRP. The run flag is set by a software strobe, or in one-shot mode by a rising edge on a trigger input. It is cleared by a software strobe, or by the A match that ends a single pulse.

Top module: `cmpwm_timer`

## Requirements
- R1: After reset the count, run flag, CCRA, CCRP and both flags are zero, and the waveform pin is low with its complement high (initial level 0, polarity 0).
- R2: While the run flag is set, pause is low and `tick` is high, the count rises by one per clock. A cycle with `tick` low leaves it unchanged.
- R3: While pause is high the count holds its value, and counting resumes from that value when pause falls.
- R4: In compare mode (mode 00) with clear-select low, a tick at count CCRP×128−1 (1023 when CCRP is 0) returns the count to zero and pulses `flag_p` for one cycle. A tick with count equal to CCRA pulses `flag_a` for one cycle.
- R5: With clear-select high in compare mode, a tick with count equal to CCRA returns the count to zero, so the period is CCRA+1 ticks, and `flag_p` never pulses.
- R6: In compare mode an A match applies the action field: 00 no change, 01 drive low, 10 drive high, 11 toggle. While the run flag is low the level equals the initial-level input. The pin is the level XOR polarity, and the twin output is its complement.
- R7: In PWM mode (10) with duplex low, the period comes from CCRP and the level is active while count < CCRA. With duplex high, the period is CCRA+1 and the level is active while count < CCRP×128.
- R8: While the run flag is low the count is zero and the PWM level is inactive. Setting the run flag again restarts counting from zero.
- R9: In single-pulse mode (11), the run flag is set by the set strobe, or by a trigger rising edge when trigger-enable is high. A trigger edge with trigger-enable low is ignored. The level equals the run flag, which an A match clears, so the pulse lasts CCRA+1 ticks. `flag_p` never pulses in this mode.
- R10: In capture mode (01), while running, the action field picks the capture edge: 00 rising, 01 falling, 10 both, 11 none. On that edge the present count is written into CCRA and `flag_a` pulses. The pin holds the initial level.
- R11: A capture event and a software CCRA write in the same cycle store the captured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| mode | input | 2 | 00 compare, 01 capture, 10 PWM, 11 single pulse |
| act_sel | input | 2 | Match action (compare) or capture edge (capture) |
| init_lvl | input | 1 | Level held before any match / while stopped |
| pol | input | 1 | Inverts the waveform pin |
| cclr_a | input | 1 | Compare mode: clear on A match instead of P |
| duplex | input | 1 | PWM: swap period and duty sources |
| pause | input | 1 | Freeze the count |
| on_set | input | 1 | Set the run flag |
| on_clr | input | 1 | Clear the run flag (wins over set) |
| trig_en | input | 1 | Allow the trigger pin to start a single pulse |
| trig_in | input | 1 | Single-pulse trigger, synchronous |
| cap_in | input | 1 | Capture input, synchronous |
| wr_a | input | 1 | Write CCRA from wr_data |
| wr_p | input | 1 | Write CCRP from wr_data low bits |
| wr_data | input | 10 | Write data |
| tmr_out | output | 1 | Waveform pin |
| tmr_out_n | output | 1 | Complement of the waveform pin |
| on_o | output | 1 | Run flag |
| cnt_o | output | 10 | Counter value |
| ccra_o | output | 10 | CCRA contents |
| ccrp_o | output | 3 | CCRP contents |
| flag_a | output | 1 | One-cycle A event flag |
| flag_p | output | 1 | One-cycle P event flag |

## Verification
The assertions take `cap_in` and `trig_in` to be synchronous to `clk`. They also take `mode` to be steady across the one or two cycles each property spans, since the flag and level checks read the previous cycle's mode. The bench changes `mode` only after the run flag has been cleared for several cycles. It drives every input half a cycle away from the rising edge, so edge detection and capture see clean one-clock levels. Configuration inputs that may change during a run (action, polarity) are never referenced through `$past` by the properties.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;
  typedef enum logic [1:0] {
    MODE_CMP = 2'b00,
    MODE_CAP = 2'b01,
    MODE_PWM = 2'b10,
    MODE_ONE = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } match_act_e;

  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;
  localparam logic [1:0] EDGE_BOTH = 2'b10;
endpackage

// File: rtl/cmpwm_count.sv
module cmpwm_count import cmpwm_pkg::*; #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pause,
  input  tmr_mode_e        mode,
  input  logic             cclr_a,
  input  logic             duplex,
  input  logic             on_set,
  input  logic             on_clr,
  input  logic             trig_en,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] ccra,
  input  logic [PER_W-1:0] ccrp,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             on_q,
  output logic             on_d,
  output logic             hit_a,
  output logic             hit_p
);
  localparam int LOW_W = CNT_W - PER_W;
  localparam logic [PER_W-1:0] ONE_P = {{(PER_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             trig_q;
  logic             run;
  logic             wrap;
  logic             trig_rise;
  logic             stop_req;
  logic             start_req;
  logic [PER_W-1:0] last_top;

  assign run       = on_q & ~pause & tick;
  assign last_top  = ccrp - ONE_P;
  assign hit_p     = run & (cnt_q[CNT_W-1:LOW_W] == last_top) & (&cnt_q[LOW_W-1:0]);
  assign hit_a     = run & (mode != MODE_CAP) & (cnt_q == ccra);
  assign trig_rise = trig_in & ~trig_q;

  always_comb begin
    case (mode)
      MODE_CMP: wrap = cclr_a ? hit_a : hit_p;
      MODE_CAP: wrap = hit_p;
      MODE_PWM: wrap = duplex ? hit_a : hit_p;
      default:  wrap = hit_a;
    endcase
  end

  always_comb begin
    if (!on_q)      cnt_d = '0;
    else if (run)   cnt_d = wrap ? '0 : cnt_q + ONE_C;
    else            cnt_d = cnt_q;
  end

  assign stop_req  = on_clr | ((mode == MODE_ONE) & hit_a);
  assign start_req = on_set | ((mode == MODE_ONE) & trig_en & trig_rise);

  always_comb begin
    if (stop_req)       on_d = 1'b0;
    else if (start_req) on_d = 1'b1;
    else                on_d = on_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      on_q   <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      on_q   <= on_d;
      trig_q <= trig_in;
    end
  end

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst) (on_q && pause) |=> (cnt_q == $past(cnt_q))); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst) $rose(on_q) |-> (cnt_q == '0)); // R8
  AST_ONE_SHOT_END: assert property (@(posedge clk) disable iff (rst) ((mode == MODE_ONE) && hit_a) |=> !on_q); // R9
endmodule

// File: rtl/cmpwm_ccr.sv
module cmpwm_ccr import cmpwm_pkg::*; #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_e        mode,
  input  logic [1:0]       edge_sel,
  input  logic             on_q,
  input  logic             cap_in,
  input  logic             wr_a,
  input  logic             wr_p,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ccra_q,
  output logic [PER_W-1:0] ccrp_q,
  output logic             cap_hit
);
  logic cap_q;
  logic rise;
  logic fall;
  logic edge_ok;

  assign rise = cap_in & ~cap_q;
  assign fall = ~cap_in & cap_q;

  always_comb begin
    case (edge_sel)
      EDGE_RISE: edge_ok = rise;
      EDGE_FALL: edge_ok = fall;
      EDGE_BOTH: edge_ok = rise | fall;
      default:   edge_ok = 1'b0;
    endcase
  end

  assign cap_hit = on_q & (mode == MODE_CAP) & edge_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= 1'b0;
      ccra_q <= '0;
      ccrp_q <= '0;
    end else begin
      cap_q <= cap_in;
      if (cap_hit)   ccra_q <= cnt_q;
      else if (wr_a) ccra_q <= wr_data;
      if (wr_p)      ccrp_q <= wr_data[PER_W-1:0];
    end
  end

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (rst) cap_hit |=> (ccra_q == $past(cnt_q))); // R10
endmodule

// File: rtl/cmpwm_wave.sv
module cmpwm_wave import cmpwm_pkg::*; #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_e        mode,
  input  match_act_e       act,
  input  logic             init_lvl,
  input  logic             cclr_a,
  input  logic             duplex,
  input  logic             on_q,
  input  logic             on_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] ccra,
  input  logic [PER_W-1:0] ccrp,
  input  logic             hit_a,
  input  logic             hit_p,
  input  logic             cap_hit,
  output logic             lvl_q,
  output logic             flag_a_q,
  output logic             flag_p_q
);
  localparam int LOW_W = CNT_W - PER_W;

  logic [CNT_W-1:0] duty_ref;
  logic             act_lvl;
  logic             lvl_d;
  logic             p_ok;

  assign duty_ref = duplex ? {ccrp, {LOW_W{1'b0}}} : ccra;

  always_comb begin
    case (act)
      ACT_LOW:    act_lvl = 1'b0;
      ACT_HIGH:   act_lvl = 1'b1;
      ACT_TOGGLE: act_lvl = ~lvl_q;
      default:    act_lvl = lvl_q;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_CMP: lvl_d = !on_d ? init_lvl : (hit_a ? act_lvl : lvl_q);
      MODE_CAP: lvl_d = init_lvl;
      MODE_PWM: lvl_d = on_d & (cnt_d < duty_ref);
      default:  lvl_d = on_d;
    endcase
  end

  assign p_ok = hit_p & ~((mode == MODE_CMP) & cclr_a) & (mode != MODE_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= 1'b0;
      flag_a_q <= 1'b0;
      flag_p_q <= 1'b0;
    end else begin
      lvl_q    <= lvl_d;
      flag_a_q <= hit_a | cap_hit;
      flag_p_q <= p_ok;
    end
  end

  AST_PWM_IDLE: assert property (@(posedge clk) disable iff (rst) ((mode == MODE_PWM) && ($past(mode) == MODE_PWM) && !on_q) |-> !lvl_q); // R8
  AST_CCLR_A_ONLY: assert property (@(posedge clk) disable iff (rst) flag_p_q |-> !(($past(mode) == MODE_CMP) && $past(cclr_a))); // R5
  AST_NO_P_ONESHOT: assert property (@(posedge clk) disable iff (rst) flag_p_q |-> ($past(mode) != MODE_ONE)); // R9
endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer import cmpwm_pkg::*; #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [1:0]       act_sel,
  input  logic             init_lvl,
  input  logic             pol,
  input  logic             cclr_a,
  input  logic             duplex,
  input  logic             pause,
  input  logic             on_set,
  input  logic             on_clr,
  input  logic             trig_en,
  input  logic             trig_in,
  input  logic             cap_in,
  input  logic             wr_a,
  input  logic             wr_p,
  input  logic [CNT_W-1:0] wr_data,
  output logic             tmr_out,
  output logic             tmr_out_n,
  output logic             on_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ccra_o,
  output logic [PER_W-1:0] ccrp_o,
  output logic             flag_a,
  output logic             flag_p
);
  tmr_mode_e        mode_e;
  match_act_e       act_e;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] ccra_q;
  logic [PER_W-1:0] ccrp_q;
  logic             on_q;
  logic             on_d;
  logic             hit_a;
  logic             hit_p;
  logic             cap_hit;
  logic             lvl_q;

  assign mode_e = tmr_mode_e'(mode);
  assign act_e  = match_act_e'(act_sel);

  cmpwm_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .pause(pause), .mode(mode_e),
    .cclr_a(cclr_a), .duplex(duplex), .on_set(on_set), .on_clr(on_clr),
    .trig_en(trig_en), .trig_in(trig_in), .ccra(ccra_q), .ccrp(ccrp_q),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .on_q(on_q), .on_d(on_d),
    .hit_a(hit_a), .hit_p(hit_p)
  );

  cmpwm_ccr #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ccr (
    .clk(clk), .rst(rst), .mode(mode_e), .edge_sel(act_sel), .on_q(on_q),
    .cap_in(cap_in), .wr_a(wr_a), .wr_p(wr_p), .wr_data(wr_data),
    .cnt_q(cnt_q), .ccra_q(ccra_q), .ccrp_q(ccrp_q), .cap_hit(cap_hit)
  );

  cmpwm_wave #(.CNT_W(CNT_W), .PER_W(PER_W)) u_wave (
    .clk(clk), .rst(rst), .mode(mode_e), .act(act_e), .init_lvl(init_lvl),
    .cclr_a(cclr_a), .duplex(duplex), .on_q(on_q), .on_d(on_d), .cnt_d(cnt_d),
    .ccra(ccra_q), .ccrp(ccrp_q), .hit_a(hit_a), .hit_p(hit_p),
    .cap_hit(cap_hit), .lvl_q(lvl_q), .flag_a_q(flag_a), .flag_p_q(flag_p)
  );

  assign tmr_out   = lvl_q ^ pol;
  assign tmr_out_n = ~tmr_out;
  assign on_o      = on_q;
  assign cnt_o     = cnt_q;
  assign ccra_o    = ccra_q;
  assign ccrp_o    = ccrp_q;
endmodule

// File: tb/cmpwm_timer_tb.sv
module cmpwm_timer_tb;
  localparam int CW = 10;
  localparam int PW = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [1:0] mode = 2'b00, act_sel = 2'b00;
  logic init_lvl = 1'b0, pol = 1'b0, cclr_a = 1'b0, duplex = 1'b0, pause = 1'b0;
  logic on_set = 1'b0, on_clr = 1'b0, trig_en = 1'b0, trig_in = 1'b0, cap_in = 1'b0;
  logic wr_a = 1'b0, wr_p = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic tmr_out, tmr_out_n, on_o, flag_a, flag_p;
  logic [CW-1:0] cnt_o, ccra_o;
  logic [PW-1:0] ccrp_o;

  always #5 clk = ~clk;

  cmpwm_timer #(.CNT_W(CW), .PER_W(PW)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .act_sel(act_sel),
    .init_lvl(init_lvl), .pol(pol), .cclr_a(cclr_a), .duplex(duplex),
    .pause(pause), .on_set(on_set), .on_clr(on_clr), .trig_en(trig_en),
    .trig_in(trig_in), .cap_in(cap_in), .wr_a(wr_a), .wr_p(wr_p),
    .wr_data(wr_data), .tmr_out(tmr_out), .tmr_out_n(tmr_out_n), .on_o(on_o),
    .cnt_o(cnt_o), .ccra_o(ccra_o), .ccrp_o(ccrp_o), .flag_a(flag_a), .flag_p(flag_p)
  );

  int m_cnt, m_on, m_lvl, m_ccra, m_ccrp, m_fa, m_fp, m_capp, m_trp;
  int errs = 0, checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  // Behavioural reference: next state from the requirements, one step per clock.
  always @(posedge clk) begin : model
    int per, nc, non, nlvl, duty;
    bit run, hp, ha, ch, rise, fall, eok, clr, trise;
    if (rst) begin
      m_cnt = 0; m_on = 0; m_lvl = 0; m_ccra = 0; m_ccrp = 0;
      m_fa = 0; m_fp = 0; m_capp = 0; m_trp = 0;
    end else begin
      per  = (m_ccrp == 0) ? 1024 : m_ccrp * 128;
      run  = (m_on != 0) && !pause && tick;
      hp   = run && (m_cnt == per - 1);
      ha   = run && (mode != 2'b01) && (m_cnt == m_ccra);
      rise = cap_in && (m_capp == 0);
      fall = !cap_in && (m_capp != 0);
      case (act_sel)
        2'd0: eok = rise;
        2'd1: eok = fall;
        2'd2: eok = rise || fall;
        default: eok = 1'b0;
      endcase
      ch    = (m_on != 0) && (mode == 2'b01) && eok;
      trise = trig_in && (m_trp == 0);
      case (mode)
        2'd0: clr = cclr_a ? ha : hp;
        2'd1: clr = hp;
        2'd2: clr = duplex ? ha : hp;
        default: clr = ha;
      endcase
      if (m_on == 0) nc = 0;
      else if (run) nc = clr ? 0 : (m_cnt + 1) % 1024;
      else nc = m_cnt;
      if (on_clr || (mode == 2'd3 && ha)) non = 0;
      else if (on_set || (mode == 2'd3 && trig_en && trise)) non = 1;
      else non = m_on;
      duty = duplex ? m_ccrp * 128 : m_ccra;
      case (mode)
        2'd0: begin
          if (non == 0) nlvl = init_lvl;
          else if (ha) begin
            case (act_sel)
              2'd0: nlvl = m_lvl;
              2'd1: nlvl = 0;
              2'd2: nlvl = 1;
              default: nlvl = 1 - m_lvl;
            endcase
          end else nlvl = m_lvl;
        end
        2'd1: nlvl = init_lvl;
        2'd2: nlvl = (non != 0 && nc < duty) ? 1 : 0;
        default: nlvl = non;
      endcase
      m_fa = (ha || ch) ? 1 : 0;
      m_fp = (hp && !(mode == 2'd0 && cclr_a) && mode != 2'd3) ? 1 : 0;
      if (ch) m_ccra = m_cnt;
      else if (wr_a) m_ccra = wr_data;
      if (wr_p) m_ccrp = wr_data % 8;
      m_cnt = nc; m_on = non; m_lvl = nlvl;
      m_capp = cap_in; m_trp = trig_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("count", cnt_o, m_cnt);
      chk("ccra", ccra_o, m_ccra);
      chk("ccrp", ccrp_o, m_ccrp);
      chk("on/pin/pin_n/fa/fp", {on_o, tmr_out, tmr_out_n, flag_a, flag_p},
          {m_on[0], m_lvl[0] ^ pol, ~(m_lvl[0] ^ pol), m_fa[0], m_fp[0]});
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic put_a(input int v);
    wr_a = 1'b1; wr_data = CW'(v); cyc(1); wr_a = 1'b0;
  endtask

  task automatic put_p(input int v);
    wr_p = 1'b1; wr_data = CW'(v); cyc(1); wr_p = 1'b0;
  endtask

  task automatic go;
    on_set = 1'b1; cyc(1); on_set = 1'b0;
  endtask

  task automatic stop;
    on_clr = 1'b1; cyc(1); on_clr = 1'b0; cyc(2);
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom % 4) != 0;
      cyc(1);
    end
    tick = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : stim
    int v, n, hi, fp_seen;
    cyc(3); rst = 1'b0; cyc(1);

    cur_req = "R1";
    chk("reset count", cnt_o, 0);
    chk("reset on", on_o, 0);
    chk("reset flags", {flag_a, flag_p}, 0);
    chk("reset pin", tmr_out, 0);
    chk("reset pin_n", tmr_out_n, 1);
    chk("reset ccra", ccra_o, 0);

    cur_req = "R2";
    mode = 2'b00; act_sel = 2'b11; put_p(1); put_a(50); tick = 1'b1; go;
    run_rand(400);
    tick = 1'b0; v = cnt_o; cyc(5);
    chk("no tick hold", cnt_o, v);
    tick = 1'b1; cyc(1);
    chk("tick step", cnt_o, (v + 1) % 128);

    cur_req = "R3";
    pause = 1'b1; v = cnt_o; cyc(6);
    chk("pause hold", cnt_o, v);
    pause = 1'b0; cyc(1);
    chk("resume step", cnt_o, (v + 1) % 128);

    cur_req = "R4";
    put_p(0); put_a(3);
    n = 0;
    while (!flag_p && n < 1100) begin cyc(1); n++; end
    cyc(1);
    chk("flag_p one cycle", flag_p, 0);
    n = 1;
    while (!flag_p && n < 1100) begin cyc(1); n++; end
    chk("full P period", n, 1024);

    cur_req = "R5";
    cclr_a = 1'b1; act_sel = 2'b10; put_a(20);
    fp_seen = 0;
    n = 0;
    while (!flag_a && n < 1100) begin cyc(1); n++; end
    cyc(1); n = 1;
    while (!flag_a && n < 100) begin fp_seen |= flag_p; cyc(1); n++; end
    chk("A clear period", n, 21);
    chk("no P flag", fp_seen, 0);
    act_sel = 2'b01; pol = 1'b1;
    run_rand(150);

    cur_req = "R6";
    stop; init_lvl = 1'b1; cyc(2);
    chk("idle init level", tmr_out, 1 ^ pol);
    pol = 1'b0; act_sel = 2'b11; cclr_a = 1'b0; init_lvl = 1'b0; put_p(1); put_a(40);
    go; run_rand(300);
    act_sel = 2'b00; run_rand(150);

    cur_req = "R7";
    stop; mode = 2'b10; duplex = 1'b0; put_p(2); put_a(60); go; cyc(5);
    hi = 0;
    for (int i = 0; i < 256; i++) begin hi += tmr_out; cyc(1); end
    chk("pwm duty normal", hi, 60);
    run_rand(300);
    stop; duplex = 1'b1; put_a(199); put_p(1); go; cyc(5);
    hi = 0;
    for (int i = 0; i < 200; i++) begin hi += tmr_out; cyc(1); end
    chk("pwm duty swapped", hi, 128);
    run_rand(300);

    cur_req = "R8";
    stop;
    chk("stopped count", cnt_o, 0);
    chk("stopped pwm level", tmr_out, 0);
    go;
    chk("restart count", cnt_o, 0);
    cyc(1);
    chk("restart step", cnt_o, 1);
    run_rand(100);

    cur_req = "R9";
    stop; mode = 2'b11; duplex = 1'b0; put_a(15); cyc(2);
    go; hi = 1;
    for (int i = 0; i < 40; i++) begin hi += tmr_out; cyc(1); end
    chk("sw pulse width", hi - 1, 16);
    chk("pulse ends run", on_o, 0);
    trig_en = 1'b1; trig_in = 1'b1; cyc(1); trig_in = 1'b0;
    hi = 1;
    for (int i = 0; i < 40; i++) begin hi += tmr_out; cyc(1); end
    chk("pin pulse width", hi - 1, 16);
    trig_en = 1'b0; trig_in = 1'b1; cyc(1); trig_in = 1'b0; cyc(3);
    chk("trigger ignored", on_o, 0);
    chk("trigger ignored pin", tmr_out, 0);

    cur_req = "R10";
    stop; mode = 2'b01; put_p(0); tick = 1'b1; go; cyc(10);
    for (int es = 0; es < 4; es++) begin
      act_sel = 2'(es);
      for (int i = 0; i < 90; i++) begin
        if (i % 9 == 0) cap_in = ~cap_in;
        cyc(1);
      end
    end
    act_sel = 2'b00; cap_in = 1'b0; cyc(3);
    v = cnt_o; cap_in = 1'b1; cyc(1);
    chk("captured count", ccra_o, v);
    chk("capture flag", flag_a, 1);

    cur_req = "R11";
    cap_in = 1'b0; cyc(3);
    v = cnt_o; cap_in = 1'b1; wr_a = 1'b1; wr_data = CW'(5); cyc(1); wr_a = 1'b0;
    chk("capture beats write", ccra_o, v);
    cyc(5);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule